// File: doc/BRIEF.md
# Nonvolatile Store/Recall Power Controller

This block decides when a shadow nonvolatile array is copied into a working SRAM, and when the SRAM is copied back into the array. It takes software store and recall requests, a write strobe from the SRAM port, two supply comparator flags and a power-fail flag. From these it produces a busy flag, a write-inhibit signal, and one word-by-word enable for each kind of transfer: clearing the SRAM, loading it from the array, and saving it into the array. The enables come with a transfer address.

A recall has two phases. First the SRAM data words are cleared, then the array contents are loaded. A software recall uses a short load interval. A recall triggered by power-up or by a brown-out uses a longer restore interval. A recall never drives the save enable, so the array is left untouched and a recall may be repeated any number of times.

A store runs for its own interval. A store started by power failure is skipped when the SRAM holds no write since the last completed store or recall. A software store always runs.

The topmost words of the address space hold clock/calendar registers. No transfer ever enables them.

Top module: `nvsr_ctrl`

## Requirements
- R1: After reset a recall is pending. It starts at the first clock edge where `vcc_above_switch` is 1 and `pwr_fail` is 0, and it uses the restore interval. With default parameters, busy stays high for CLEAR_CYC+RESTORE_CYC = 50 cycles.
- R2: A recall begins with a clear phase of CLEAR_CYC cycles, followed by a load phase. In phase cycle k (k from 0), the phase enable is high when k < DATA_WORDS, and then `xfer_addr` = k. The clear phase drives `sram_clear_en` and the load phase drives `nv_to_sram_en`. `sram_to_nv_en` is never high during a recall.
- R3: The load phase lasts RECALL_CYC cycles for a software recall. It lasts RESTORE_CYC cycles for a recall latched by reset or by a brown-out.
- R4: The top RTC_WORDS addresses (default 14 and 15) never see an enable. Every enable pulse carries `xfer_addr` < DATA_WORDS = 2^AW − RTC_WORDS.
- R5: A store lasts STORE_CYC cycles. In cycle k of the store, `sram_to_nv_en` is high when k < DATA_WORDS, and then `xfer_addr` = k.
- R6: A software store pulse is accepted only while the block is idle and `vcc_above_switch` is 1. It runs even when no write has occurred. Any other software store pulse is dropped.
- R7: While the block is idle, `pwr_fail` starts a store only if the dirty flag is set. This happens regardless of the supply flags. With a clean SRAM, no store occurs.
- R8: The dirty flag is set by an accepted write, meaning `wr_strobe` is 1 while `wr_inhibit` is 0. It is cleared in the last cycle of any store or recall.
- R9: When `vcc_above_reset` is 0, a recall of restore type is latched. It starts once the block is idle, `vcc_above_switch` is 1 and `pwr_fail` is 0.
- R10: `wr_inhibit` is 1 exactly when busy is 1 or `vcc_above_switch` is 0. Writes made while it is 1 do not set the dirty flag.
- R11: A recall request that arrives during a store waits for the store to finish. Busy then drops for exactly one cycle, and the recall starts. When several requests are ready in the idle state, the power-fail store wins over a pending recall, and a pending recall wins over a software store. A software recall pulse in the cycle a recall starts merges into that recall.
- R12: Busy is 0 in reset and while idle. It is 1 for every cycle of a store or recall, and each transfer enable is high only while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_above_reset | input | 1 | Supply above the reset threshold |
| vcc_above_switch | input | 1 | Supply above the switch threshold |
| pwr_fail | input | 1 | Power is failing; store on hold-up energy |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| wr_strobe | input | 1 | SRAM write attempt |
| busy | output | 1 | Store or recall in progress |
| wr_inhibit | output | 1 | SRAM writes must be blocked |
| sram_clear_en | output | 1 | Clear the SRAM word at xfer_addr |
| nv_to_sram_en | output | 1 | Copy the array word at xfer_addr into SRAM |
| sram_to_nv_en | output | 1 | Copy the SRAM word at xfer_addr into the array |
| xfer_addr | output | AW | Word address of the current transfer step |

## Verification
The assertions assume that the supply flags are consistent: `vcc_above_switch` is never 1 while `vcc_above_reset` is 0. They also assume that every input is synchronous to `clk`. The random stimulus enforces this by drawing a supply regime (good, sagging below switch, or browned out) and holding it for a random stretch. Each regime fixes both comparator flags together. Request pulses and power-fail events are drawn at low rates within each regime, so collisions with a busy interval, priority collisions in idle, and power failure during brown-out all occur.

// File: rtl/nvsr_pkg.sv
// Shared types for the store/recall controller.
package nvsr_pkg;

    // Controller phase: idle, SRAM clear, array-to-SRAM load, SRAM-to-array save.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_LOAD  = 2'd2,
        PH_SAVE  = 2'd3
    } phase_t;

endpackage

// File: rtl/nvsr_req.sv
// Request latch: holds the pending recall and its type (power or software),
// and the dirty flag. Assumes a recall is never taken while the supply is
// below the reset threshold.
module nvsr_req (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_above_reset,
    input  logic sw_recall_req,
    input  logic wr_accept,
    input  logic recall_take,
    input  logic op_done,
    output logic rcl_pend,
    output logic rcl_pwr,
    output logic dirty
);

    // Pending recall: reset and brown-out latch the power type; software adds its own.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcl_pend <= 1'b1;
            rcl_pwr  <= 1'b1;
        end else if (!vcc_above_reset) begin
            rcl_pend <= 1'b1;
            rcl_pwr  <= 1'b1;
        end else if (recall_take) begin
            rcl_pend <= 1'b0;
        end else if (sw_recall_req) begin
            rcl_pend <= 1'b1;
            rcl_pwr  <= rcl_pend ? rcl_pwr : 1'b0;
        end
    end

    // Dirty flag: set by an accepted write, cleared when a transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (op_done) begin
            dirty <= 1'b0;
        end else if (wr_accept) begin
            dirty <= 1'b1;
        end
    end

endmodule

// File: rtl/nvsr_timer.sv
// Phase interval counter. A start pulse loads a new length and restarts the
// count at zero. While run is high the count advances, and last is high in
// the final cycle. Assumes len >= 1.
module nvsr_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] cnt,
    output logic          last
);

    logic [CW-1:0] len_r;

    assign last = run && (cnt == (len_r - CW'(1)));

    // Count register: load on start, advance while running, park at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            len_r <= '0;
        end else if (start) begin
            cnt   <= '0;
            len_r <= len;
        end else if (run && !last) begin
            cnt <= cnt + CW'(1);
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/nvsr_fsm.sv
// Phase sequencer. In idle it picks the next operation in priority order:
// power-fail store, then pending recall, then software store. It then steps
// through the phases using the timer's last flag.
module nvsr_fsm
    import nvsr_pkg::*;
#(
    parameter int CW          = 6,
    parameter int CLEAR_CYC   = 18,
    parameter int RECALL_CYC  = 20,
    parameter int RESTORE_CYC = 32,
    parameter int STORE_CYC   = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vcc_above_switch,
    input  logic          pwr_fail,
    input  logic          sw_store_req,
    input  logic          rcl_pend,
    input  logic          rcl_pwr,
    input  logic          dirty,
    input  logic          t_last,
    output phase_t        phase,
    output logic          t_start,
    output logic [CW-1:0] t_len,
    output logic          recall_take,
    output logic          op_done
);

    phase_t phase_nx;
    logic   load_pwr;
    logic   load_pwr_nx;

    // Next-phase decision and timer load.
    always_comb begin
        phase_nx    = phase;
        load_pwr_nx = load_pwr;
        t_start     = 1'b0;
        t_len       = CW'(STORE_CYC);
        recall_take = 1'b0;
        op_done     = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (pwr_fail && dirty) begin
                    phase_nx = PH_SAVE;
                    t_start  = 1'b1;
                    t_len    = CW'(STORE_CYC);
                end else if (rcl_pend && vcc_above_switch && !pwr_fail) begin
                    phase_nx    = PH_CLEAR;
                    t_start     = 1'b1;
                    t_len       = CW'(CLEAR_CYC);
                    recall_take = 1'b1;
                    load_pwr_nx = rcl_pwr;
                end else if (sw_store_req && vcc_above_switch) begin
                    phase_nx = PH_SAVE;
                    t_start  = 1'b1;
                    t_len    = CW'(STORE_CYC);
                end
            end
            PH_CLEAR: begin
                if (t_last) begin
                    phase_nx = PH_LOAD;
                    t_start  = 1'b1;
                    t_len    = load_pwr ? CW'(RESTORE_CYC) : CW'(RECALL_CYC);
                end
            end
            PH_LOAD, PH_SAVE: begin
                if (t_last) begin
                    phase_nx = PH_IDLE;
                    op_done  = 1'b1;
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase and recall-type registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            load_pwr <= 1'b0;
        end else begin
            phase    <= phase_nx;
            load_pwr <= load_pwr_nx;
        end
    end

endmodule

// File: rtl/nvsr_ctrl.sv
// Store/recall power controller top. It ties together the request latch, the
// phase sequencer and the interval timer, and decodes the per-word transfer
// enables. The upper RTC_WORDS addresses are never enabled. Assumes every
// phase length is at least 2^AW cycles, and that the supply flags are
// synchronous to clk.
module nvsr_ctrl
    import nvsr_pkg::*;
#(
    parameter int AW          = 4,
    parameter int RTC_WORDS   = 2,
    parameter int CLEAR_CYC   = 18,
    parameter int RECALL_CYC  = 20,
    parameter int RESTORE_CYC = 32,
    parameter int STORE_CYC   = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vcc_above_reset,
    input  logic          vcc_above_switch,
    input  logic          pwr_fail,
    input  logic          sw_store_req,
    input  logic          sw_recall_req,
    input  logic          wr_strobe,
    output logic          busy,
    output logic          wr_inhibit,
    output logic          sram_clear_en,
    output logic          nv_to_sram_en,
    output logic          sram_to_nv_en,
    output logic [AW-1:0] xfer_addr
);

    localparam int WORDS      = 1 << AW;
    localparam int DATA_WORDS = WORDS - RTC_WORDS;
    localparam int MAX_A      = (CLEAR_CYC > RECALL_CYC) ? CLEAR_CYC : RECALL_CYC;
    localparam int MAX_B      = (RESTORE_CYC > STORE_CYC) ? RESTORE_CYC : STORE_CYC;
    localparam int MAXLEN     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW         = $clog2(MAXLEN + 1);

    phase_t        phase;
    logic          t_start;
    logic          t_last;
    logic [CW-1:0] t_len;
    logic [CW-1:0] t_cnt;
    logic          recall_take;
    logic          op_done;
    logic          rcl_pend;
    logic          rcl_pwr;
    logic          dirty;
    logic          in_data;

    assign busy       = (phase != PH_IDLE);
    assign wr_inhibit = busy || !vcc_above_switch;

    nvsr_req u_req (
        .clk             (clk),
        .rst_n           (rst_n),
        .vcc_above_reset (vcc_above_reset),
        .sw_recall_req   (sw_recall_req),
        .wr_accept       (wr_strobe && !wr_inhibit),
        .recall_take     (recall_take),
        .op_done         (op_done),
        .rcl_pend        (rcl_pend),
        .rcl_pwr         (rcl_pwr),
        .dirty           (dirty)
    );

    nvsr_fsm #(
        .CW          (CW),
        .CLEAR_CYC   (CLEAR_CYC),
        .RECALL_CYC  (RECALL_CYC),
        .RESTORE_CYC (RESTORE_CYC),
        .STORE_CYC   (STORE_CYC)
    ) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .vcc_above_switch (vcc_above_switch),
        .pwr_fail         (pwr_fail),
        .sw_store_req     (sw_store_req),
        .rcl_pend         (rcl_pend),
        .rcl_pwr          (rcl_pwr),
        .dirty            (dirty),
        .t_last           (t_last),
        .phase            (phase),
        .t_start          (t_start),
        .t_len            (t_len),
        .recall_take      (recall_take),
        .op_done          (op_done)
    );

    nvsr_timer #(
        .CW (CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .run   (busy),
        .len   (t_len),
        .cnt   (t_cnt),
        .last  (t_last)
    );

    // Word sweep: the step count is the address; clock words at the top are masked.
    assign in_data       = (t_cnt < CW'(DATA_WORDS));
    assign xfer_addr     = t_cnt[AW-1:0];
    assign sram_clear_en = (phase == PH_CLEAR) && in_data;
    assign nv_to_sram_en = (phase == PH_LOAD)  && in_data;
    assign sram_to_nv_en = (phase == PH_SAVE)  && in_data;

endmodule

// File: rtl/nvsr_ctrl_chk.sv
// Property checker for nvsr_ctrl, attached by bind. It observes only the
// top-level ports.
module nvsr_ctrl_chk #(
    parameter int AW         = 4,
    parameter int DATA_WORDS = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vcc_above_switch,
    input logic          pwr_fail,
    input logic          busy,
    input logic          wr_inhibit,
    input logic          sram_clear_en,
    input logic          nv_to_sram_en,
    input logic          sram_to_nv_en,
    input logic [AW-1:0] xfer_addr
);

    logic any_en;
    assign any_en = sram_clear_en || nv_to_sram_en || sram_to_nv_en;

    assert_one_transfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_clear_en, nv_to_sram_en, sram_to_nv_en}));

    assert_enable_needs_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        any_en |-> busy);

    assert_rtc_skipped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_en |-> ({1'b0, xfer_addr} < (AW+1)'(DATA_WORDS)));

    assert_inhibit_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || !vcc_above_switch) |-> wr_inhibit);

    assert_inhibit_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && vcc_above_switch) |-> !wr_inhibit);

    assert_clear_ascends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_clear_en && $past(sram_clear_en)) |-> (xfer_addr == $past(xfer_addr) + AW'(1)));

    assert_load_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_to_sram_en) |-> (xfer_addr == '0));

    assert_recall_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_clear_en) |-> ($past(vcc_above_switch) && !$past(pwr_fail)));

endmodule

bind nvsr_ctrl nvsr_ctrl_chk #(
    .AW         (AW),
    .DATA_WORDS (DATA_WORDS)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .vcc_above_switch (vcc_above_switch),
    .pwr_fail         (pwr_fail),
    .busy             (busy),
    .wr_inhibit       (wr_inhibit),
    .sram_clear_en    (sram_clear_en),
    .nv_to_sram_en    (nv_to_sram_en),
    .sram_to_nv_en    (sram_to_nv_en),
    .xfer_addr        (xfer_addr)
);

// File: tb/nvsr_ctrl_tb.sv
// Bench for nvsr_ctrl: directed corner cases, then seeded random supply
// regimes. A cycle model built from the requirements is checked every cycle.
module nvsr_ctrl_tb;

    localparam int CLK_PERIOD  = 10;
    localparam int AW          = 4;
    localparam int RTC_WORDS   = 2;
    localparam int CLEAR_CYC   = 18;
    localparam int RECALL_CYC  = 20;
    localparam int RESTORE_CYC = 32;
    localparam int STORE_CYC   = 24;
    localparam int DATA_WORDS  = (1 << AW) - RTC_WORDS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_above_reset = 1'b1;
    logic vcc_above_switch = 1'b1;
    logic pwr_fail = 1'b0;
    logic sw_store_req = 1'b0;
    logic sw_recall_req = 1'b0;
    logic wr_strobe = 1'b0;
    logic busy, wr_inhibit, sram_clear_en, nv_to_sram_en, sram_to_nv_en;
    logic [AW-1:0] xfer_addr;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    bit model_ok = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvsr_ctrl #(
        .AW(AW), .RTC_WORDS(RTC_WORDS), .CLEAR_CYC(CLEAR_CYC),
        .RECALL_CYC(RECALL_CYC), .RESTORE_CYC(RESTORE_CYC), .STORE_CYC(STORE_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .vcc_above_reset(vcc_above_reset),
        .vcc_above_switch(vcc_above_switch), .pwr_fail(pwr_fail),
        .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
        .wr_strobe(wr_strobe), .busy(busy), .wr_inhibit(wr_inhibit),
        .sram_clear_en(sram_clear_en), .nv_to_sram_en(nv_to_sram_en),
        .sram_to_nv_en(sram_to_nv_en), .xfer_addr(xfer_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Expected phase length for a phase (0 idle, 1 clear, 2 load, 3 save).
    function automatic int phase_len(input int ph, input bit pwr_type);
        case (ph)
            1: return CLEAR_CYC;
            2: return pwr_type ? RESTORE_CYC : RECALL_CYC;
            3: return STORE_CYC;
            default: return 0;
        endcase
    endfunction

    // Cycle model state derived from the requirements.
    int m_ph, m_cnt, m_len;
    bit m_pend, m_pwr, m_dirty, m_ld;
    int n_ph, n_cnt, n_len;
    bit take, done;

    always @(posedge clk) begin
        model_ok <= 1'b1;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_len = 0;
            m_pend = 1; m_pwr = 1; m_dirty = 0; m_ld = 0;
        end else begin
            take = 0; done = 0;
            n_ph = m_ph; n_cnt = m_cnt + 1; n_len = m_len;
            if (m_ph == 0) begin
                n_cnt = 0;
                if (pwr_fail && m_dirty) begin
                    n_ph = 3; n_len = phase_len(3, 0);
                end else if (m_pend && vcc_above_switch && !pwr_fail) begin
                    n_ph = 1; n_len = phase_len(1, 0); take = 1; m_ld = m_pwr;
                end else if (sw_store_req && vcc_above_switch) begin
                    n_ph = 3; n_len = phase_len(3, 0);
                end
            end else if (m_cnt == m_len - 1) begin
                n_cnt = 0;
                if (m_ph == 1) begin
                    n_ph = 2; n_len = phase_len(2, m_ld);
                end else begin
                    n_ph = 0; done = 1;
                end
            end
            if (done) m_dirty = 0;
            else if (wr_strobe && m_ph == 0 && vcc_above_switch) m_dirty = 1;
            if (!vcc_above_reset) begin m_pend = 1; m_pwr = 1; end
            else if (take) m_pend = 0;
            else if (sw_recall_req) begin m_pwr = m_pend ? m_pwr : 1'b0; m_pend = 1; end
            m_ph = n_ph; m_cnt = n_cnt; m_len = n_len;
        end
    end

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #1;
        if (model_ok) begin
            bit e_busy, e_clr, e_ld, e_sv;
            e_busy = (m_ph != 0);
            e_clr  = (m_ph == 1) && (m_cnt < DATA_WORDS);
            e_ld   = (m_ph == 2) && (m_cnt < DATA_WORDS);
            e_sv   = (m_ph == 3) && (m_cnt < DATA_WORDS);
            chk(busy == e_busy, "R12 busy", int'(busy), int'(e_busy));
            chk(wr_inhibit == (e_busy || !vcc_above_switch), "R10 wr_inhibit",
                int'(wr_inhibit), int'(e_busy || !vcc_above_switch));
            chk(sram_clear_en == e_clr, "R2 sram_clear_en", int'(sram_clear_en), int'(e_clr));
            chk(nv_to_sram_en == e_ld, "R2 nv_to_sram_en", int'(nv_to_sram_en), int'(e_ld));
            chk(sram_to_nv_en == e_sv, "R5 sram_to_nv_en", int'(sram_to_nv_en), int'(e_sv));
            if (e_clr || e_ld || e_sv)
                chk(int'(xfer_addr) == m_cnt, "R4 xfer_addr", int'(xfer_addr), m_cnt);
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    // Busy length from the next rise (or the current high cycle) to the fall.
    task automatic meas(output int n);
        int guard;
        guard = 0; n = 0;
        while (!busy && guard < 500) begin @(negedge clk); #2; guard++; end
        while (busy && guard < 1000) begin n++; @(negedge clk); #2; guard++; end
    endtask

    task automatic no_busy(input int n, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); #2; if (busy) seen++; end
        chk(seen == 0, tag, seen, 0);
    endtask

    task automatic pulse_store();
        @(negedge clk); sw_store_req = 1'b1;
        @(negedge clk); sw_store_req = 1'b0;
    endtask

    task automatic pulse_write();
        @(negedge clk); wr_strobe = 1'b1;
        @(negedge clk); wr_strobe = 1'b0;
    endtask

    initial begin
        int n, regime;
        void'($urandom(32'd4711));

        // Reset state.
        repeat (3) @(negedge clk);
        #2;
        chk(busy == 1'b0, "R12 reset busy", int'(busy), 0);
        chk(sram_clear_en == 1'b0, "R12 reset clear enable", int'(sram_clear_en), 0);

        // R1: power-up recall with the restore interval.
        @(negedge clk); rst_n = 1'b1;
        #2;
        meas(n);
        chk(n == CLEAR_CYC + RESTORE_CYC, "R1 power-up recall length", n, CLEAR_CYC + RESTORE_CYC);

        // R3: a software recall uses the shorter load interval.
        @(negedge clk); sw_recall_req = 1'b1;
        @(negedge clk); sw_recall_req = 1'b0;
        #2;
        meas(n);
        chk(n == CLEAR_CYC + RECALL_CYC, "R3 software recall length", n, CLEAR_CYC + RECALL_CYC);

        // R7: power failure with a clean SRAM does not store.
        @(negedge clk); pwr_fail = 1'b1;
        no_busy(10, "R7 clean power-fail skipped");
        @(negedge clk); pwr_fail = 1'b0;

        // R7/R8: a write then power failure stores once; dirty then clears.
        pulse_write();
        @(negedge clk); pwr_fail = 1'b1;
        #2;
        meas(n);
        chk(n == STORE_CYC, "R7 dirty power-fail store length", n, STORE_CYC);
        no_busy(10, "R8 dirty cleared after store");
        @(negedge clk); pwr_fail = 1'b0;

        // R6: a software store runs while clean; writes during busy are ignored (R10).
        pulse_store();
        #2;
        chk(busy == 1'b1, "R6 software store while clean", int'(busy), 1);
        @(negedge clk); wr_strobe = 1'b1;
        repeat (3) @(negedge clk);
        wr_strobe = 1'b0;
        #2;
        meas(n);
        @(negedge clk); pwr_fail = 1'b1;
        no_busy(10, "R10 write while busy ignored");
        @(negedge clk); pwr_fail = 1'b0;

        // R10: a write below the switch threshold is ignored.
        @(negedge clk); vcc_above_switch = 1'b0;
        pulse_write();
        @(negedge clk); vcc_above_switch = 1'b1; pwr_fail = 1'b1;
        no_busy(10, "R10 write below switch ignored");
        @(negedge clk); pwr_fail = 1'b0;

        // R6: a software store below the switch threshold is dropped.
        @(negedge clk); vcc_above_switch = 1'b0;
        pulse_store();
        no_busy(5, "R6 store below switch dropped");
        @(negedge clk); vcc_above_switch = 1'b1;
        no_busy(3, "R6 dropped store not retried");

        // R11: a recall during a store waits; one idle cycle; then the recall runs.
        pulse_store();
        repeat (2) @(negedge clk);
        sw_recall_req = 1'b1;
        @(negedge clk); sw_recall_req = 1'b0;
        #2;
        meas(n);
        chk(n == STORE_CYC - 3, "R11 store not cut short", n, STORE_CYC - 3);
        @(negedge clk); #2;
        chk(busy == 1'b1, "R11 held recall starts after one idle cycle", int'(busy), 1);
        meas(n);
        chk(n == CLEAR_CYC + RECALL_CYC, "R11 held recall length", n, CLEAR_CYC + RECALL_CYC);

        // R9: a brown-out latches a restore-type recall that waits for the switch level.
        @(negedge clk); vcc_above_reset = 1'b0; vcc_above_switch = 1'b0;
        no_busy(5, "R9 no recall during brown-out");
        @(negedge clk); vcc_above_reset = 1'b1;
        no_busy(5, "R9 no recall below switch");
        @(negedge clk); vcc_above_switch = 1'b1;
        #2;
        meas(n);
        chk(n == CLEAR_CYC + RESTORE_CYC, "R9 brown-out recall length", n, CLEAR_CYC + RESTORE_CYC);

        // Random supply regimes, checked against the model each cycle.
        regime = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if ($urandom % 40 == 0) regime = int'($urandom % 4);
            vcc_above_reset  = (regime != 2);
            vcc_above_switch = (regime == 0) || (regime == 3);
            pwr_fail      = (regime == 0) ? ($urandom % 60 == 0) : ($urandom % 4 == 0);
            sw_store_req  = ($urandom % 25 == 0);
            sw_recall_req = ($urandom % 40 == 0);
            wr_strobe     = ($urandom % 3 == 0);
        end
        @(negedge clk);
        pwr_fail = 1'b0; sw_store_req = 1'b0; sw_recall_req = 1'b0; wr_strobe = 1'b0;
        repeat (5) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule